// File: doc/BRIEF.md
# DDR input capture register

This block takes a single-ended data bus that carries two words per clock period, one per clock edge, and turns it into two words per period. Both words are delivered together, in step with one edge of the capture clock. The block sits straight behind an input pad in an FPGA fabric design. One typical use is to feed read data from a double-data-rate memory into logic that runs at the single rate.

One register triggered on the falling edge takes the first word of each pair. A register triggered on the rising edge takes the second word. A level-sensitive latch is open while the capture clock is high. It passes the falling-edge word on, so that both output words change at the same rising edge. A parameter swaps the edge roles so that the first word is taken on the rising edge instead. Optional controls are a clock enable, an asynchronous clear or set, and a synchronous clear or set. When no asynchronous control is in use, a parameter picks the power-up value. An elaboration error rejects any configuration that enables both the clear and the set of one kind.

Top module: `ddr_in_capture`

## Requirements
- R1: With FIRST_ON_RISE=0, `dout_lo` carries the `din` value present at the falling edge of `clk` that comes before the capturing rising edge.
- R2: With FIRST_ON_RISE=0, `dout_hi` carries the `din` value present at the rising edge of `clk`. Both words of a pair appear one rising edge after the second word arrives.
- R3: `dout_lo` changes only at the rising edge of the capture clock. Across the falling edge it keeps the word of the previous pair, even though a new word is taken in internally.
- R4: With FIRST_ON_RISE=1, the first word is taken on the rising edge of `clk` and goes to `dout_lo`. The second word is taken on the falling edge and goes to `dout_hi`. Both outputs update at the falling edge of `clk`.
- R5: While `ena` is low across a whole clock period, no capture register takes new data and both outputs hold their values.
- R6: The enabled asynchronous control (`aclr` forces all bits to 0, `aset` forces all bits to 1) acts at once, without a clock edge. It overrides the clock and `ena`.
- R7: The enabled synchronous control (`sclr` forces 0, `sset` forces 1) acts only on a capture edge where `ena` is high, and there it overrides `din`. When `ena` is low it has no effect.
- R8: With no asynchronous control enabled, all registers and the latch power up to all ones when POWERUP_HIGH=1 and to all zeros otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| ena | input | 1 | Clock enable for every capture register |
| aclr | input | 1 | Asynchronous clear, used when USE_ACLR=1 |
| aset | input | 1 | Asynchronous set, used when USE_ASET=1 |
| sclr | input | 1 | Synchronous clear, used when USE_SCLR=1 |
| sset | input | 1 | Synchronous set, used when USE_SSET=1 |
| din | input | WIDTH | Double-rate data from the pad |
| dout_hi | output | WIDTH | Word taken on the rising capture edge |
| dout_lo | output | WIDTH | Word taken on the falling capture edge, moved to the rising edge |

## Verification
The hardest case to reach from the ports is the half period after a falling edge. Here the internal falling-edge register already holds the next word, yet `dout_lo` must still show the old one. The bench reaches it by sampling `dout_lo` just after a falling edge in the middle of a pair. It then samples again after the next rising edge. The hold and override cases are brought about in a similar way. The enable, the synchronous controls and the asynchronous controls are each changed a quarter period away from any edge. In the asynchronous case the change comes while `ena` is low, so that no edge can explain the new output value.

// File: rtl/ddrc_pkg.sv
package ddrc_pkg;
  typedef enum logic [1:0] {
    FORCE_NONE = 2'd0,
    FORCE_LOW  = 2'd1,
    FORCE_HIGH = 2'd2
  } force_e;

  function automatic force_e force_kind(bit use_clr, bit use_set);
    if (use_set) return FORCE_HIGH;
    if (use_clr) return FORCE_LOW;
    return FORCE_NONE;
  endfunction
endpackage

// File: rtl/ddrc_edge_reg.sv
module ddrc_edge_reg #(
  parameter int W        = 8,
  parameter bit FALLING  = 1'b0,
  parameter bit USE_ACLR = 1'b0,
  parameter bit USE_ASET = 1'b0,
  parameter bit USE_SCLR = 1'b0,
  parameter bit USE_SSET = 1'b0,
  parameter bit PWR_HIGH = 1'b0
) (
  input  logic         clk,
  input  logic         en,
  input  logic         aclr,
  input  logic         aset,
  input  logic         sclr,
  input  logic         sset,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  import ddrc_pkg::*;

  localparam force_e         AKIND     = force_kind(USE_ACLR, USE_ASET);
  localparam force_e         SKIND     = force_kind(USE_SCLR, USE_SSET);
  localparam bit             HAS_ASYNC = (AKIND != FORCE_NONE);
  localparam logic [W-1:0]   INIT      = {W{PWR_HIGH}};
  localparam logic [W-1:0]   AVAL      = {W{AKIND == FORCE_HIGH}};
  localparam logic [W-1:0]   SVAL      = {W{SKIND == FORCE_HIGH}};

  logic         eclk;
  logic         a_on;
  logic         s_on;
  logic [W-1:0] nxt;
  // stored relative to the power-up value, so a 2-state zero start gives INIT
  bit   [W-1:0] st;

  assign eclk = FALLING ? ~clk : clk;
  assign a_on = (USE_ACLR && aclr) || (USE_ASET && aset);
  assign s_on = (USE_SCLR && sclr) || (USE_SSET && sset);
  assign nxt  = s_on ? SVAL : d;

  generate
    if (HAS_ASYNC) begin : g_async
      always_ff @(posedge eclk or posedge a_on) begin
        if (a_on)    st <= AVAL ^ INIT;
        else if (en) st <= nxt ^ INIT;
      end
    end else begin : g_plain
      always_ff @(posedge eclk) begin
        if (en) st <= nxt ^ INIT;
      end
    end
  endgenerate

  assign q = st ^ INIT;
endmodule

// File: rtl/ddrc_resync_latch.sv
module ddrc_resync_latch #(
  parameter int W        = 8,
  parameter bit USE_ACLR = 1'b0,
  parameter bit USE_ASET = 1'b0,
  parameter bit PWR_HIGH = 1'b0
) (
  input  logic         gate,
  input  logic         aclr,
  input  logic         aset,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  import ddrc_pkg::*;

  localparam force_e       AKIND = force_kind(USE_ACLR, USE_ASET);
  localparam logic [W-1:0] INIT  = {W{PWR_HIGH}};
  localparam logic [W-1:0] AVAL  = {W{AKIND == FORCE_HIGH}};

  logic         a_on;
  bit   [W-1:0] st;

  assign a_on = (USE_ACLR && aclr) || (USE_ASET && aset);

  // open while the capture clock is high: follows the falling-edge word
  always_latch begin
    if (a_on)      st = AVAL ^ INIT;
    else if (gate) st = d ^ INIT;
  end

  assign q = st ^ INIT;
endmodule

// File: rtl/ddr_in_capture.sv
module ddr_in_capture #(
  parameter int WIDTH         = 8,
  parameter bit FIRST_ON_RISE = 1'b0,
  parameter bit USE_ACLR      = 1'b1,
  parameter bit USE_ASET      = 1'b0,
  parameter bit USE_SCLR      = 1'b1,
  parameter bit USE_SSET      = 1'b0,
  parameter bit POWERUP_HIGH  = 1'b0
) (
  input  logic             clk,
  input  logic             ena,
  input  logic             aclr,
  input  logic             aset,
  input  logic             sclr,
  input  logic             sset,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout_hi,
  output logic [WIDTH-1:0] dout_lo
);
  generate
    if (USE_ACLR && USE_ASET) begin : g_bad_async
      $error("ddr_in_capture: asynchronous clear and set are both enabled");
    end
    if (USE_SCLR && USE_SSET) begin : g_bad_sync
      $error("ddr_in_capture: synchronous clear and set are both enabled");
    end
  endgenerate

  logic             cap_clk;
  logic [WIDTH-1:0] first_q;

  assign cap_clk = FIRST_ON_RISE ? ~clk : clk;

  ddrc_edge_reg #(
    .W(WIDTH), .FALLING(1'b1),
    .USE_ACLR(USE_ACLR), .USE_ASET(USE_ASET),
    .USE_SCLR(USE_SCLR), .USE_SSET(USE_SSET),
    .PWR_HIGH(POWERUP_HIGH)
  ) u_first (
    .clk(cap_clk), .en(ena), .aclr(aclr), .aset(aset),
    .sclr(sclr), .sset(sset), .d(din), .q(first_q)
  );

  ddrc_edge_reg #(
    .W(WIDTH), .FALLING(1'b0),
    .USE_ACLR(USE_ACLR), .USE_ASET(USE_ASET),
    .USE_SCLR(USE_SCLR), .USE_SSET(USE_SSET),
    .PWR_HIGH(POWERUP_HIGH)
  ) u_second (
    .clk(cap_clk), .en(ena), .aclr(aclr), .aset(aset),
    .sclr(sclr), .sset(sset), .d(din), .q(dout_hi)
  );

  ddrc_resync_latch #(
    .W(WIDTH), .USE_ACLR(USE_ACLR), .USE_ASET(USE_ASET),
    .PWR_HIGH(POWERUP_HIGH)
  ) u_resync (
    .gate(cap_clk), .aclr(aclr), .aset(aset), .d(first_q), .q(dout_lo)
  );
endmodule

// File: rtl/ddrc_checker.sv
module ddrc_checker #(
  parameter int W        = 8,
  parameter bit USE_ACLR = 1'b0,
  parameter bit USE_ASET = 1'b0,
  parameter bit USE_SCLR = 1'b0,
  parameter bit USE_SSET = 1'b0
) (
  input logic         cap_clk,
  input logic         ena,
  input logic         aclr,
  input logic         aset,
  input logic         sclr,
  input logic         sset,
  input logic [W-1:0] din,
  input logic [W-1:0] dout_hi,
  input logic [W-1:0] dout_lo
);
  localparam logic [W-1:0] AVAL = {W{USE_ASET}};
  localparam logic [W-1:0] SVAL = {W{USE_SSET}};

  logic         a_on;
  logic         s_on;
  logic         n_ok;
  logic [W-1:0] n_word;
  logic         e_ok;
  logic [W-1:0] e_word;

  assign a_on = (USE_ACLR && aclr) || (USE_ASET && aset);
  assign s_on = (USE_SCLR && sclr) || (USE_SSET && sset);

  always_ff @(negedge cap_clk or posedge a_on) begin
    if (a_on) begin
      n_ok   <= 1'b0;
      n_word <= '0;
    end else begin
      n_ok   <= ena && !s_on;
      n_word <= din;
    end
  end

  always_ff @(posedge cap_clk or posedge a_on) begin
    if (a_on) begin
      e_ok   <= 1'b0;
      e_word <= '0;
    end else begin
      e_ok   <= n_ok;
      e_word <= n_word;
    end
  end

  AST_HI_TAKES_DATA: assert property (@(posedge cap_clk) disable iff (a_on)
    (ena && !s_on) |=> (dout_hi == $past(din))); // R2
  AST_LO_FROM_FALL: assert property (@(negedge cap_clk) disable iff (a_on)
    e_ok |-> (dout_lo == e_word)); // R3
  AST_HOLD_IDLE: assert property (@(posedge cap_clk) disable iff (a_on)
    !ena |=> $stable(dout_hi)); // R5
  AST_ASYNC_FORCE: assert property (@(posedge cap_clk)
    a_on |-> ((dout_hi == AVAL) && (dout_lo == AVAL))); // R6
  AST_SYNC_FORCE: assert property (@(posedge cap_clk) disable iff (a_on)
    (ena && s_on) |=> (dout_hi == SVAL)); // R7
endmodule

bind ddr_in_capture ddrc_checker #(
  .W(WIDTH), .USE_ACLR(USE_ACLR), .USE_ASET(USE_ASET),
  .USE_SCLR(USE_SCLR), .USE_SSET(USE_SSET)
) u_chk (
  .cap_clk(cap_clk), .ena(ena), .aclr(aclr), .aset(aset),
  .sclr(sclr), .sset(sset), .din(din), .dout_hi(dout_hi), .dout_lo(dout_lo)
);

// File: tb/sim_ddr_in_capture.sv
`timescale 1ns/1ps
module sim_ddr_in_capture;
  logic       clk = 1'b0;
  logic       ena0, aclr0, sclr0;
  logic [7:0] d0, hi0, lo0;
  logic       aset1, sset1;
  logic [7:0] d1, hi1, lo1;
  logic [7:0] hi2, lo2;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ddr_in_capture #(.WIDTH(8), .FIRST_ON_RISE(1'b0), .USE_ACLR(1'b1), .USE_ASET(1'b0),
    .USE_SCLR(1'b1), .USE_SSET(1'b0), .POWERUP_HIGH(1'b0)) u0 (
    .clk(clk), .ena(ena0), .aclr(aclr0), .aset(1'b0), .sclr(sclr0), .sset(1'b0),
    .din(d0), .dout_hi(hi0), .dout_lo(lo0));

  ddr_in_capture #(.WIDTH(8), .FIRST_ON_RISE(1'b1), .USE_ACLR(1'b0), .USE_ASET(1'b1),
    .USE_SCLR(1'b0), .USE_SSET(1'b1), .POWERUP_HIGH(1'b0)) u1 (
    .clk(clk), .ena(1'b1), .aclr(1'b0), .aset(aset1), .sclr(1'b0), .sset(sset1),
    .din(d1), .dout_hi(hi1), .dout_lo(lo1));

  ddr_in_capture #(.WIDTH(8), .FIRST_ON_RISE(1'b0), .USE_ACLR(1'b0), .USE_ASET(1'b0),
    .USE_SCLR(1'b0), .USE_SSET(1'b0), .POWERUP_HIGH(1'b1)) u2 (
    .clk(clk), .ena(1'b1), .aclr(1'b0), .aset(1'b0), .sclr(1'b0), .sset(1'b0),
    .din(8'h00), .dout_hi(hi2), .dout_lo(lo2));

  function automatic logic [7:0] forced(bit high);
    return {8{high}};
  endfunction

  function automatic logic [7:0] pick(bit ctl_on, bit high, logic [7:0] data);
    return ctl_on ? forced(high) : data;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // u0: starts just after a rising edge, ends just after the next rising edge
  task automatic pair0(logic [7:0] a, logic [7:0] b);
    d0 = a;
    @(negedge clk); #2;
    d0 = b;
    @(posedge clk); #2;
  endtask

  // u1: starts just after a falling edge, ends just after the next falling edge
  task automatic pair1(logic [7:0] a, logic [7:0] b);
    d1 = a;
    @(posedge clk); #2;
    d1 = b;
    @(negedge clk); #2;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] a, b, ph, pl;
    void'($urandom(32'd4242));
    ena0 = 1'b1; aclr0 = 1'b1; sclr0 = 1'b0; d0 = 8'h00;
    aset1 = 1'b1; sset1 = 1'b0; d1 = 8'h00;
    #1;
    chk("R8 power-up hi", hi2, forced(1'b1));
    chk("R8 power-up lo", lo2, forced(1'b1));
    chk("R6 reset hi u0", hi0, forced(1'b0));
    chk("R6 reset lo u0", lo0, forced(1'b0));
    chk("R6 preset hi u1", hi1, forced(1'b1));
    chk("R6 preset lo u1", lo1, forced(1'b1));
    @(posedge clk); #2;
    aclr0 = 1'b0; aset1 = 1'b0;

    // R1 R2: random stream, one word per edge
    for (int i = 0; i < 40; i++) begin
      a = 8'($urandom); b = 8'($urandom);
      pair0(a, b);
      chk("R2 hi word", hi0, b);
      chk("R1 lo word", lo0, a);
    end

    // R3: lo must not move at the falling edge
    pair0(8'h5A, 8'hC3);
    d0 = 8'h11;
    @(negedge clk); #2;
    chk("R3 lo held across fall", lo0, 8'h5A);
    chk("R3 hi held across fall", hi0, 8'hC3);
    d0 = 8'h22;
    @(posedge clk); #2;
    chk("R3 lo at rise", lo0, 8'h11);
    chk("R2 hi at rise", hi0, 8'h22);

    // R5: enable low for a whole period
    ph = hi0; pl = lo0;
    ena0 = 1'b0;
    pair0(8'h99, 8'h66);
    chk("R5 hold hi", hi0, ph);
    chk("R5 hold lo", lo0, pl);
    ena0 = 1'b1;
    pair0(8'h3C, 8'hE1);
    chk("R5 resume hi", hi0, 8'hE1);
    chk("R5 resume lo", lo0, 8'h3C);

    // R7: synchronous clear beats data, ignored while disabled
    sclr0 = 1'b1;
    pair0(8'hFF, 8'hFF);
    chk("R7 sclr hi", hi0, pick(1'b1, 1'b0, 8'hFF));
    chk("R7 sclr lo", lo0, pick(1'b1, 1'b0, 8'hFF));
    sclr0 = 1'b0;
    pair0(8'hA5, 8'h5A);
    ena0 = 1'b0; sclr0 = 1'b1;
    pair0(8'h00, 8'h00);
    chk("R7 sclr ignored hi", hi0, 8'h5A);
    chk("R7 sclr ignored lo", lo0, 8'hA5);
    sclr0 = 1'b0;

    // R6: async clear between edges with enable low
    #1 aclr0 = 1'b1;
    #1;
    chk("R6 aclr hi", hi0, forced(1'b0));
    chk("R6 aclr lo", lo0, forced(1'b0));
    ena0 = 1'b1;
    pair0(8'h77, 8'h88);
    chk("R6 aclr over clock hi", hi0, forced(1'b0));
    chk("R6 aclr over clock lo", lo0, forced(1'b0));
    aclr0 = 1'b0;
    pair0(8'h12, 8'h34);
    chk("R2 after aclr hi", hi0, 8'h34);
    chk("R1 after aclr lo", lo0, 8'h12);

    // R4: inverted capture on u1
    @(negedge clk); #2;
    for (int i = 0; i < 20; i++) begin
      a = 8'($urandom); b = 8'($urandom);
      pair1(a, b);
      chk("R4 first word on lo", lo1, a);
      chk("R4 second word on hi", hi1, b);
    end
    pair1(8'h4B, 8'hB4);
    d1 = 8'h0F;
    @(posedge clk); #2;
    chk("R4 lo held across rise", lo1, 8'h4B);
    chk("R4 hi held across rise", hi1, 8'hB4);
    d1 = 8'hF0;
    @(negedge clk); #2;
    chk("R4 lo at fall", lo1, 8'h0F);
    chk("R4 hi at fall", hi1, 8'hF0);

    // R7 set variant, R6 set variant
    sset1 = 1'b1;
    pair1(8'h01, 8'h02);
    chk("R7 sset hi", hi1, pick(1'b1, 1'b1, 8'h02));
    chk("R7 sset lo", lo1, pick(1'b1, 1'b1, 8'h01));
    sset1 = 1'b0;
    pair1(8'h10, 8'h20);
    chk("R4 after sset hi", hi1, 8'h20);
    #1 aset1 = 1'b1;
    #1;
    chk("R6 aset hi", hi1, forced(1'b1));
    chk("R6 aset lo", lo1, forced(1'b1));
    aset1 = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule